// File: doc/BRIEF.md
# Dual-Mode Bipolar Zero-Substitution Decoder

This block sits behind the data slicer of a high-rate line receiver. On every edge of the recovered receive clock it takes one line symbol as two rail bits: one marks a positive pulse and the other marks a negative pulse. It produces the binary data that was sent. The transmitter replaced long runs of zeros with codes that contain a deliberate polarity violation. The decoder finds those codes and turns them back into zeros. A mode input picks the four-symbol code (HDB3, used on E3 lines) or the three-symbol code (B3ZS, used on DS3 and STS-1 lines).

Every symbol goes through a fixed four-stage pipeline. This gives the decoder time to cancel a balancing pulse that came before the violation that identifies it. While the symbol moves through the pipeline, the control logic checks the line for faults that break the selected code: a violation pulse in the wrong place, a pulse on both rails at once, or too many zeros in a row. It marks each fault with a one-cycle flag, which leaves the pipeline in the same cycle as the faulty symbol. A disable input turns the block into a plain pulse detector with the same latency.

Top module: `bipolarZsDecoder`

## Requirements
- R1: With `decodeOff` = 1, `dataOut` is 1 for each symbol that has a pulse on either rail and 0 for each empty symbol, and `lcvOut` stays 0.
- R2: While reset is active and for the first three clock edges after it is released, `dataValid`, `dataOut` and `lcvOut` are 0. From the fourth edge on, `dataValid` is 1. Output cycle k carries the symbol sampled on the rails at edge k-3, so every symbol has four edges of latency.
- R3: With `hdb3Mode` = 1, the group zero, zero, zero, V decodes as four zeros. V is a pulse of the same polarity as the previous pulse.
- R4: With `hdb3Mode` = 1, the group B, zero, zero, V decodes as four zeros. B is a pulse of opposite polarity to the pulse before it, and V has the same polarity as B.
- R5: With `hdb3Mode` = 0, the groups zero, zero, V and B, zero, V each decode as three zeros.
- R6: A pulse that alternates in polarity with the previous pulse decodes as 1, an empty symbol decodes as 0, and a correctly coded stream raises no flag.
- R7: A same-polarity pulse that does not complete a substitution group flags `lcvOut` and decodes as 1. In HDB3 this means either of the two symbols before it holds a pulse. In B3ZS it means the symbol just before it holds a pulse.
- R8: With `hdb3Mode` = 1, the fourth empty symbol in a row and each further one flags `lcvOut`. Three empty symbols in a row do not.
- R9: With `hdb3Mode` = 0, the third empty symbol in a row and each further one flags `lcvOut`.
- R10: A symbol with pulses on both rails flags `lcvOut` and decodes as 1. It does not change the remembered polarity.
- R11: After reset no flag is raised until the first pulse has been received, so leading empty symbols and a first pulse of either polarity are accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered receive clock |
| rstN | input | 1 | Active-low synchronous reset |
| hdb3Mode | input | 1 | 1 selects the four-symbol code (HDB3), 0 selects the three-symbol code (B3ZS) |
| decodeOff | input | 1 | 1 bypasses decoding and fault checks |
| railPos | input | 1 | Positive-pulse rail bit for this symbol |
| railNeg | input | 1 | Negative-pulse rail bit for this symbol |
| dataOut | output | 1 | Decoded data bit |
| dataValid | output | 1 | High once the pipeline holds received symbols |
| lcvOut | output | 1 | One-cycle line code violation flag, aligned with the faulty symbol's `dataOut` |

## Verification
The bench encodes random data of several densities in both codes. Sparse data forces many back-to-back substitutions of both shapes. A decoder that mistook a balancing pulse for data, or cleared the wrong pipeline stage, would leave stray ones or wipe real data. Directed streams test where the zero-run flag starts in each mode: a threshold off by one would flag a legal three-zero gap in HDB3 or miss one in B3ZS. The bench also sends a both-rails pulse followed by a pulse of the other polarity, which catches a design that lets the double pulse update the remembered polarity. Leading zeros and a negative first pulse after reset catch a design that checks polarity before it has seen any pulse.

// File: rtl/bipolarZsPkg.sv
package bipolarZsPkg;
  localparam int HDB3_SPAN = 4;
  localparam int B3ZS_SPAN = 3;
  localparam int MAX_CLEAR = HDB3_SPAN - 1;

  typedef struct packed {
    logic                 pulse;
    logic                 dataBit;
    logic                 lcv;
    logic [MAX_CLEAR-1:0] clearMask;
  } zsStrobes_t;
endpackage

// File: rtl/zsDecCtrl.sv
module zsDecCtrl
  import bipolarZsPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hdb3Mode,
  input  logic                 decodeOff,
  input  logic                 railPos,
  input  logic                 railNeg,
  input  logic [MAX_CLEAR-1:0] recentPulse,
  output zsStrobes_t           strobes
);
  logic lastPos, seenPulse;
  logic pulse, both, single, repeatPol, leadOk, quietRun, active, subHit;
  logic [MAX_CLEAR-1:0] clrVec;

  always_comb begin
    pulse     = railPos | railNeg;
    both      = railPos & railNeg;
    single    = pulse & ~both;
    repeatPol = single & seenPulse & (railPos == lastPos);
    // zeros that must sit directly before a legal violation pulse
    leadOk    = hdb3Mode ? (recentPulse[1:0] == 2'b00) : ~recentPulse[0];
    // incoming zero that would extend the run past the legal length
    quietRun  = hdb3Mode ? (recentPulse[2:0] == 3'b000) : (recentPulse[1:0] == 2'b00);
    active    = ~decodeOff;
    subHit    = active & repeatPol & leadOk;
  end

  for (genvar k = 0; k < MAX_CLEAR; k++) begin : g_clr
    localparam bit IN_HDB3 = (k < HDB3_SPAN - 1);
    localparam bit IN_B3ZS = (k < B3ZS_SPAN - 1);
    assign clrVec[k] = subHit & (hdb3Mode ? IN_HDB3 : IN_B3ZS);
  end

  always_comb begin
    strobes.pulse     = pulse;
    strobes.dataBit   = pulse & ~subHit;
    strobes.lcv       = active & ((repeatPol & ~leadOk) | both |
                                  (~pulse & seenPulse & quietRun));
    strobes.clearMask = clrVec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastPos   <= 1'b0;
      seenPulse <= 1'b0;
    end else begin
      if (single) lastPos <= railPos;
      if (pulse) seenPulse <= 1'b1;
    end
  end
endmodule

// File: rtl/zsDecPipe.sv
module zsDecPipe
  import bipolarZsPkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  zsStrobes_t           strobes,
  output logic [MAX_CLEAR-1:0] recentPulse,
  output logic                 dataOut,
  output logic                 dataValid,
  output logic                 lcvOut
);
  localparam int LAST = LATENCY - 1;

  if (LATENCY < HDB3_SPAN) begin : g_bad
    $error("LATENCY must cover the longest substitution group");
  end

  logic [MAX_CLEAR-1:0] rawQ;
  logic [LATENCY-1:0]   datQ, lcvQ, vldQ;

  for (genvar k = 0; k < MAX_CLEAR; k++) begin : g_raw
    always_ff @(posedge clk) begin
      if (!rstN) rawQ[k] <= 1'b0;
      else if (k == 0) rawQ[k] <= strobes.pulse;
      else rawQ[k] <= rawQ[(k == 0) ? 0 : k-1];
    end
  end

  for (genvar k = 0; k < LATENCY; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rstN) begin
          datQ[0] <= 1'b0; lcvQ[0] <= 1'b0; vldQ[0] <= 1'b0;
        end else begin
          datQ[0] <= strobes.dataBit;
          lcvQ[0] <= strobes.lcv;
          vldQ[0] <= 1'b1;
        end
      end
    end else if (k - 1 < MAX_CLEAR) begin : g_clearable
      always_ff @(posedge clk) begin
        if (!rstN) begin
          datQ[k] <= 1'b0; lcvQ[k] <= 1'b0; vldQ[k] <= 1'b0;
        end else begin
          datQ[k] <= datQ[k-1] & ~strobes.clearMask[k-1];
          lcvQ[k] <= lcvQ[k-1];
          vldQ[k] <= vldQ[k-1];
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN) begin
          datQ[k] <= 1'b0; lcvQ[k] <= 1'b0; vldQ[k] <= 1'b0;
        end else begin
          datQ[k] <= datQ[k-1];
          lcvQ[k] <= lcvQ[k-1];
          vldQ[k] <= vldQ[k-1];
        end
      end
    end
  end

  assign recentPulse = rawQ;
  assign dataOut     = datQ[LAST];
  assign lcvOut      = lcvQ[LAST];
  assign dataValid   = vldQ[LAST];
endmodule

// File: rtl/bipolarZsDecoder.sv
module bipolarZsDecoder
  import bipolarZsPkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic hdb3Mode,
  input  logic decodeOff,
  input  logic railPos,
  input  logic railNeg,
  output logic dataOut,
  output logic dataValid,
  output logic lcvOut
);
  zsStrobes_t           strobes;
  logic [MAX_CLEAR-1:0] recentPulse;

  zsDecCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .hdb3Mode(hdb3Mode), .decodeOff(decodeOff),
    .railPos(railPos), .railNeg(railNeg), .recentPulse(recentPulse),
    .strobes(strobes)
  );

  zsDecPipe #(.LATENCY(LATENCY)) pipe_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .recentPulse(recentPulse),
    .dataOut(dataOut), .dataValid(dataValid), .lcvOut(lcvOut)
  );
endmodule

// File: rtl/zsDecChecker.sv
module zsDecChecker (
  input logic clk,
  input logic rstN,
  input logic hdb3Mode,
  input logic decodeOff,
  input logic railPos,
  input logic railNeg,
  input logic dataOut,
  input logic dataValid,
  input logic lcvOut
);
  logic anyPulse;
  always_ff @(posedge clk) begin
    if (!rstN) anyPulse <= 1'b0;
    else if (railPos | railNeg) anyPulse <= 1'b1;
  end

  // R1: bypass copies the pulse presence and never flags
  a_r1_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && $past(decodeOff, 1) && $past(decodeOff, 2) &&
     $past(decodeOff, 3) && $past(decodeOff, 4))
    |-> (dataOut == $past(railPos | railNeg, 4)) && !lcvOut);

  // R2: once valid, stays valid until reset
  a_r2_valid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> dataValid);

  // R2: nothing leaves an unfilled pipeline
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> (!dataOut && !lcvOut));

  // R10: a double-rail pulse is always flagged when decoding
  a_r10_both_rails: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && $past(railPos && railNeg, 4) && !$past(decodeOff, 4))
    |-> lcvOut);

  // R11: no flag before any pulse has arrived
  a_r11_quiet_start: assert property (@(posedge clk) disable iff (!rstN)
    lcvOut |-> anyPulse);
endmodule

bind bipolarZsDecoder zsDecChecker chk_i (
  .clk(clk), .rstN(rstN), .hdb3Mode(hdb3Mode), .decodeOff(decodeOff),
  .railPos(railPos), .railNeg(railNeg), .dataOut(dataOut),
  .dataValid(dataValid), .lcvOut(lcvOut)
);

// File: tb/bipolarZsDecoder_tb.sv
module bipolarZsDecoder_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hdb3Mode = 1'b1;
  logic decodeOff = 1'b0;
  logic railPos = 1'b0;
  logic railNeg = 1'b0;
  logic dataOut, dataValid, lcvOut;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  bit symP [0:511];
  bit symN [0:511];
  bit expD [0:511];
  bit expL [0:511];
  int nSym = 0;

  always #10 clk = ~clk;

  bipolarZsDecoder dut_i (
    .clk(clk), .rstN(rstN), .hdb3Mode(hdb3Mode), .decodeOff(decodeOff),
    .railPos(railPos), .railNeg(railNeg), .dataOut(dataOut),
    .dataValid(dataValid), .lcvOut(lcvOut)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // s: 1 positive, -1 negative, 0 empty, 2 both rails
  task automatic pushSym(input int s, input bit d, input bit l);
    symP[nSym] = (s == 1) || (s == 2);
    symN[nSym] = (s == -1) || (s == 2);
    expD[nSym] = d;
    expL[nSym] = l;
    nSym++;
  endtask

  task automatic runStream(input bit mode, input bit off, input string tag);
    rstN = 1'b0; railPos = 1'b0; railNeg = 1'b0;
    hdb3Mode = mode; decodeOff = off;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < nSym + 4; i++) begin
      if (i < 4) begin
        check(!dataValid && !dataOut && !lcvOut,
              $sformatf("R2 %s fill cycle %0d", tag, i),
              {dataValid, dataOut, lcvOut}, 0);
      end else begin
        check(dataValid, $sformatf("R2 %s valid at %0d", tag, i), dataValid, 1);
        check({dataOut, lcvOut} == {expD[i-4], expL[i-4]},
              $sformatf("%s symbol %0d {data,lcv}", tag, i - 4),
              {dataOut, lcvOut}, {expD[i-4], expL[i-4]});
      end
      railPos = (i < nSym) ? symP[i] : 1'b0;
      railNeg = (i < nSym) ? symN[i] : 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic buildCoded(input bit mode, input int n, input int den);
    bit dat [0:511];
    int span;
    int cnt;
    int i;
    bit lastPos;
    bit allZero;
    span = mode ? 4 : 3;
    cnt = 0; i = 0; lastPos = 1'b0; nSym = 0;
    dat[0] = 1'b1;
    for (int j = 1; j < n; j++) dat[j] = (($urandom % den) == 0);
    while (i < n) begin
      allZero = (i + span <= n);
      for (int j = 0; j < span; j++) if (allZero && dat[i+j]) allZero = 1'b0;
      if (dat[i]) begin
        lastPos = !lastPos;
        pushSym(lastPos ? 1 : -1, 1'b1, 1'b0);
        cnt++; i++;
      end else if (allZero) begin
        if (cnt % 2 == 1) begin
          for (int j = 0; j < span - 1; j++) pushSym(0, 1'b0, 1'b0);
          pushSym(lastPos ? 1 : -1, 1'b0, 1'b0);
        end else begin
          lastPos = !lastPos;
          pushSym(lastPos ? 1 : -1, 1'b0, 1'b0);
          for (int j = 0; j < span - 2; j++) pushSym(0, 1'b0, 1'b0);
          pushSym(lastPos ? 1 : -1, 1'b0, 1'b0);
        end
        cnt = 0; i += span;
      end else begin
        pushSym(0, 1'b0, 1'b0);
        i++;
      end
    end
  endtask

  initial begin
    // R3 R4 R6: coded random data, four-symbol code, several densities
    for (int d = 1; d <= 3; d++) begin
      buildCoded(1'b1, 250, 1 << d);
      runStream(1'b1, 1'b0, "R3 R4 R6 hdb3 random");
    end
    // R5 R6: coded random data, three-symbol code
    for (int d = 1; d <= 3; d++) begin
      buildCoded(1'b0, 250, 1 << d);
      runStream(1'b0, 1'b0, "R5 R6 b3zs random");
    end

    // R1: bypass with arbitrary rail patterns, both modes
    for (int m = 0; m < 2; m++) begin
      nSym = 0;
      for (int j = 0; j < 60; j++) begin
        int s;
        s = int'($urandom % 4);
        pushSym((s == 3) ? -1 : s, s != 0, 1'b0);
      end
      runStream(m[0], 1'b1, "R1 bypass");
    end

    // R7: pulse repeats polarity right after a pulse (hdb3)
    nSym = 0;
    pushSym(1, 1, 0); pushSym(-1, 1, 0); pushSym(-1, 1, 1); pushSym(1, 1, 0);
    runStream(1'b1, 1'b0, "R7 hdb3 misplaced violation");

    // R7: same in b3zs
    nSym = 0;
    pushSym(1, 1, 0); pushSym(1, 1, 1); pushSym(-1, 1, 0);
    runStream(1'b0, 1'b0, "R7 b3zs misplaced violation");

    // R5: explicit zero-zero-V in b3zs after a data pulse
    nSym = 0;
    pushSym(1, 1, 0); pushSym(0, 0, 0); pushSym(0, 0, 0); pushSym(1, 0, 0);
    pushSym(-1, 1, 0);
    runStream(1'b0, 1'b0, "R5 b3zs 00V");

    // R8: five zeros in hdb3 flag the fourth and fifth
    nSym = 0;
    pushSym(1, 1, 0);
    for (int j = 1; j <= 5; j++) pushSym(0, 0, j >= 4);
    pushSym(-1, 1, 0);
    runStream(1'b1, 1'b0, "R8 hdb3 zero run");

    // R8: three zeros are legal in hdb3
    nSym = 0;
    pushSym(1, 1, 0); pushSym(0, 0, 0); pushSym(0, 0, 0); pushSym(0, 0, 0);
    pushSym(-1, 1, 0);
    runStream(1'b1, 1'b0, "R8 hdb3 three zeros legal");

    // R9: three zeros flag in b3zs
    nSym = 0;
    pushSym(1, 1, 0); pushSym(0, 0, 0); pushSym(0, 0, 0); pushSym(0, 0, 1);
    pushSym(0, 0, 1); pushSym(-1, 1, 0);
    runStream(1'b0, 1'b0, "R9 b3zs zero run");

    // R10: both rails flagged, polarity memory kept at negative
    nSym = 0;
    pushSym(-1, 1, 0); pushSym(2, 1, 1); pushSym(1, 1, 0); pushSym(-1, 1, 0);
    runStream(1'b1, 1'b0, "R10 both rails");

    // R11: leading zeros and a negative first pulse are accepted
    for (int m = 0; m < 2; m++) begin
      nSym = 0;
      for (int j = 0; j < 5; j++) pushSym(0, 0, 0);
      pushSym(-1, 1, 0); pushSym(0, 0, 0); pushSym(1, 1, 0); pushSym(0, 0, 0);
      runStream(m[0], 1'b0, "R11 first pulse");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule